// File: doc/BRIEF.md
# Flash Read-Mode Response Multiplexer

This block forms the read data of a parallel NOR flash model. It does not track the command sequence. A separate sequencer supplies the current command state on every cycle, and this block picks what a read returns. Depending on the state, a read returns array bytes, identifier codes, a status byte whose bit 6 toggles on each read, or an entry of the device query table.

The array storage lives outside the block. The block passes the read address to the storage on `arr_addr` and receives four consecutive bytes back on `arr_bytes`, with the byte at the address itself in bits 7:0. It then assembles those bytes into 1, 2 or 4-byte results in the byte order that `big_endian` selects. Identifier codes, sector geometry and therefore the query table all come from parameters. The result is registered and valid one clock after the strobe.

Top module: `flash_rd_mux`

## Requirements
- R1: A read strobe sampled on a clock edge yields `rd_data` and a one-cycle `rd_valid` pulse from that edge. When no strobe is present, `rd_valid` is 0 and `rd_data` holds its previous value.
- R2: A 1-byte read (`rd_width` 2'b00) in array mode returns the byte at `rd_addr` in bits 7:0, with bits 31:8 at zero.
- R3: Multi-byte array reads (`rd_width` 2'b01 = 2 bytes, 2'b10 or 2'b11 = 4 bytes) handle byte order as follows. When `big_endian` is 1, the byte at the lowest address goes in the most significant position. When it is 0, that byte goes in the least significant position. Unused upper bits are zero.
- R4: The word offset used in identifier and query modes is the low 8 address bits, unshifted for width 2'b00, shifted right by 1 for 2'b01, and shifted right by 2 otherwise.
- R5: In identifier mode (`cmd_state` 3'd2), offset 0 returns the first identifier, offset 1 returns the second, and offset 2 returns 0 (no sector protected).
- R6: In identifier mode, offsets 0x0E and 0x0F return the third and fourth identifiers, or array data when that identifier's low byte is 0xFF. Every other offset returns array data.
- R7: In busy mode (`cmd_state` 3'd3), a read returns `stat_base` with bit 6 XORed by an internal toggle. Each such read inverts the toggle, so back-to-back status reads differ in bit 6.
- R8: In query mode (`cmd_state` 3'd4), offsets below 0x52 return the table entry and offsets 0x52 and above return 0. Entry contents: 0x10/0x11/0x12 = 'Q','R','Y'; 0x27 = log2 of the device size in bytes; 0x2D/0x2E = sector count minus one (low byte, high byte); 0x2F/0x30 = sector size bits 15:8 and 23:16; 0x31 = 'P'.
- R9: Idle (3'd0), erase prefix (3'd1) and the unused codes 3'd5 to 3'd7 return array data.
- R10: After reset, `rd_data` is 0, `rd_valid` is 0 and the status toggle is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_width | input | 2 | Access width code |
| cmd_state | input | 3 | Command state from the sequencer |
| big_endian | input | 1 | Byte order for multi-byte array reads |
| stat_base | input | 8 | Status byte held by the sequencer |
| arr_addr | output | ADDR_W | Address presented to the array storage |
| arr_bytes | input | 32 | Four array bytes starting at `arr_addr`, lowest address in bits 7:0 |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | High one cycle after a read strobe |

## Verification
The bench uses the default geometry of 16 sectors of 4096 bytes. That makes the device size 64 KiB, so the query table's size entry is 0x10, the sector-count entries are 0x0F and 0x00, and the sector-size entries are 0x10 and 0x00, all of which can be checked against hand-worked values. The fourth identifier is set to 0x00FF and the third to 0x2210. A single build therefore covers both the identifier path and the fallback to array data at offsets 0x0E and 0x0F.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ERPRE  = 3'd1,
        ST_IDENT  = 3'd2,
        ST_BUSY   = 3'd3,
        ST_QUERY  = 3'd4
    } cmd_state_e;

    typedef enum logic [1:0] {
        W_BYTE = 2'b00,
        W_HALF = 2'b01,
        W_WORD = 2'b10
    } rd_width_e;

    localparam int          QRY_LEN   = 82;
    localparam logic [7:0]  QRY_LIMIT = 8'h52;

    // Word offset for mode reads: low 8 address bits scaled by access width.
    function automatic logic [7:0] mode_offset(input logic [7:0] lo, input logic [1:0] w);
        logic [7:0] r;
        case (w)
            W_BYTE:  r = lo;
            W_HALF:  r = {1'b0, lo[7:1]};
            default: r = {2'b00, lo[7:2]};
        endcase
        return r;
    endfunction

    // Query table entry computed from geometry.
    function automatic logic [7:0] qry_entry(
        input logic [7:0]  idx,
        input logic [7:0]  size_log2,
        input logic [15:0] nsect_m1,
        input logic [15:0] sect_mid
    );
        logic [7:0] r;
        case (idx)
            8'h10: r = 8'h51;
            8'h11: r = 8'h52;
            8'h12: r = 8'h59;
            8'h13: r = 8'h02;
            8'h15: r = 8'h31;
            8'h1B: r = 8'h27;
            8'h1C: r = 8'h36;
            8'h1F: r = 8'h07;
            8'h21: r = 8'h09;
            8'h22: r = 8'h0C;
            8'h23: r = 8'h01;
            8'h25: r = 8'h0A;
            8'h26: r = 8'h0D;
            8'h27: r = size_log2;
            8'h28: r = 8'h02;
            8'h2C: r = 8'h01;
            8'h2D: r = nsect_m1[7:0];
            8'h2E: r = nsect_m1[15:8];
            8'h2F: r = sect_mid[7:0];
            8'h30: r = sect_mid[15:8];
            8'h31: r = 8'h50;
            8'h32: r = 8'h52;
            8'h33: r = 8'h49;
            8'h34: r = 8'h31;
            8'h35: r = 8'h30;
            default: r = 8'h00;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/flash_rd_lanes.sv
module flash_rd_lanes
    import flash_rd_pkg::*;
(
    input  logic [31:0] bytes_in,
    input  logic [1:0]  width,
    input  logic        big_endian,
    output logic [31:0] word_out
);
    logic [7:0] b [4];

    for (genvar k = 0; k < 4; k++) begin : g_split
        assign b[k] = bytes_in[8*k +: 8];
    end

    always_comb begin
        case (width)
            W_BYTE:  word_out = {24'h0, b[0]};
            W_HALF:  word_out = big_endian ? {16'h0, b[0], b[1]} : {16'h0, b[1], b[0]};
            default: word_out = big_endian ? {b[0], b[1], b[2], b[3]} : {b[3], b[2], b[1], b[0]};
        endcase
    end
endmodule

// File: rtl/flash_rd_status.sv
module flash_rd_status (
    input  logic       clk,
    input  logic       rst,
    input  logic       hit,
    input  logic [7:0] base,
    output logic [7:0] stat_out
);
    logic tog_q;

    always_ff @(posedge clk) begin
        if (rst)      tog_q <= 1'b0;
        else if (hit) tog_q <= ~tog_q;
    end

    assign stat_out = base ^ {1'b0, tog_q, 6'b0};
endmodule

// File: rtl/flash_rd_query.sv
module flash_rd_query
    import flash_rd_pkg::*;
#(
    parameter logic [7:0]  SIZE_LOG2 = 8'd16,
    parameter logic [15:0] NSECT_M1  = 16'd15,
    parameter logic [15:0] SECT_MID  = 16'h0010
) (
    input  logic [7:0] offset,
    output logic [7:0] entry
);
    logic [7:0] tbl [QRY_LEN];

    for (genvar i = 0; i < QRY_LEN; i++) begin : g_tbl
        assign tbl[i] = qry_entry(8'(i), SIZE_LOG2, NSECT_M1, SECT_MID);
    end

    assign entry = (offset < QRY_LIMIT) ? tbl[offset[6:0]] : 8'h00;
endmodule

// File: rtl/flash_rd_mux.sv
module flash_rd_mux
    import flash_rd_pkg::*;
#(
    parameter int          SECT_BYTES = 4096,
    parameter int          NUM_SECT   = 16,
    parameter logic [15:0] IDENT0     = 16'h0001,
    parameter logic [15:0] IDENT1     = 16'h227E,
    parameter logic [15:0] IDENT2     = 16'h2210,
    parameter logic [15:0] IDENT3     = 16'h2201,
    localparam int         ADDR_W     = $clog2(SECT_BYTES * NUM_SECT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [1:0]        rd_width,
    input  logic [2:0]        cmd_state,
    input  logic              big_endian,
    input  logic [7:0]        stat_base,
    output logic [ADDR_W-1:0] arr_addr,
    input  logic [31:0]       arr_bytes,
    output logic [31:0]       rd_data,
    output logic              rd_valid
);
    localparam logic [31:0] SECT_VEC   = 32'(SECT_BYTES);
    localparam logic [7:0]  SIZE_LOG2  = 8'(ADDR_W);
    localparam logic [15:0] NSECT_M1   = 16'(NUM_SECT - 1);
    localparam logic [15:0] SECT_MID   = SECT_VEC[23:8];

    logic [7:0]  offset;
    logic [31:0] arr_word;
    logic [7:0]  stat_byte;
    logic [7:0]  qry_byte;
    logic        stat_hit;
    logic [31:0] next_data;
    cmd_state_e  st;

    assign st       = cmd_state_e'(cmd_state);
    assign arr_addr = rd_addr;
    assign offset   = mode_offset(rd_addr[7:0], rd_width);
    assign stat_hit = rd_en && (st == ST_BUSY);

    flash_rd_lanes u_lanes (
        .bytes_in   (arr_bytes),
        .width      (rd_width),
        .big_endian (big_endian),
        .word_out   (arr_word)
    );

    flash_rd_status u_stat (
        .clk      (clk),
        .rst      (rst),
        .hit      (stat_hit),
        .base     (stat_base),
        .stat_out (stat_byte)
    );

    flash_rd_query #(
        .SIZE_LOG2 (SIZE_LOG2),
        .NSECT_M1  (NSECT_M1),
        .SECT_MID  (SECT_MID)
    ) u_qry (
        .offset (offset),
        .entry  (qry_byte)
    );

    always_comb begin
        next_data = arr_word;
        case (st)
            ST_IDENT: begin
                case (offset)
                    8'h00: next_data = {16'h0, IDENT0};
                    8'h01: next_data = {16'h0, IDENT1};
                    8'h02: next_data = 32'h0;
                    8'h0E: if (IDENT2[7:0] != 8'hFF) next_data = {16'h0, IDENT2};
                    8'h0F: if (IDENT3[7:0] != 8'hFF) next_data = {16'h0, IDENT3};
                    default: next_data = arr_word;
                endcase
            end
            ST_BUSY:  next_data = {24'h0, stat_byte};
            ST_QUERY: next_data = {24'h0, qry_byte};
            default:  next_data = arr_word;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= 32'h0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= next_data;
        end
    end
endmodule

// File: rtl/flash_rd_chk.sv
module flash_rd_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [1:0]        rd_width,
    input logic [2:0]        cmd_state,
    input logic              big_endian,
    input logic [7:0]        stat_base,
    input logic [31:0]       rd_data,
    input logic              rd_valid
);
    logic [7:0] off_c;
    always_comb begin
        case (rd_width)
            2'b00:   off_c = rd_addr[7:0];
            2'b01:   off_c = {1'b0, rd_addr[7:1]};
            default: off_c = {2'b00, rd_addr[7:2]};
        endcase
    end

    logic busy_rd;
    assign busy_rd = rd_en && (cmd_state == 3'd3);

    AST_VALID_AFTER: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid) else $error("valid missing"); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (!rd_valid && $stable(rd_data))) else $error("hold broken"); // R1
    AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_width == 2'b00 && cmd_state == 3'd0) |=> (rd_data[31:8] == 24'h0)) else $error("byte ext"); // R2
    AST_ID_UNPROT: assert property (@(posedge clk) disable iff (rst)
        (rd_en && cmd_state == 3'd2 && off_c == 8'h02) |=> (rd_data == 32'h0)) else $error("prot"); // R5
    AST_STAT_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        ($past(busy_rd, 2) && $past(busy_rd, 1) && ($past(stat_base, 2) == $past(stat_base, 1)))
        |-> (rd_data[6] != $past(rd_data[6]))) else $error("toggle"); // R7
    AST_QRY_BEYOND: assert property (@(posedge clk) disable iff (rst)
        (rd_en && cmd_state == 3'd4 && off_c >= 8'h52) |=> (rd_data == 32'h0)) else $error("qry range"); // R8
    AST_STAT_UPPER: assert property (@(posedge clk) disable iff (rst)
        busy_rd |=> (rd_data[31:8] == 24'h0 && rd_data[7] == $past(stat_base[7]))) else $error("stat"); // R7
    AST_BE_UNUSED: assert property (@(posedge clk) disable iff (rst)
        (rd_en && cmd_state == 3'd0 && rd_width == 2'b01) |=> (rd_data[31:16] == 16'h0)) else $error("half"); // R3

    logic unused_be;
    assign unused_be = big_endian;
endmodule

bind flash_rd_mux flash_rd_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_width   (rd_width),
    .cmd_state  (cmd_state),
    .big_endian (big_endian),
    .stat_base  (stat_base),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid)
);

// File: tb/sim_flash_rd_mux.sv
`timescale 1ns/1ps
module sim_flash_rd_mux;
    localparam int CLK_P = 10;
    localparam logic [15:0] ID0 = 16'h0001, ID1 = 16'h227E, ID2 = 16'h2210, ID3 = 16'h00FF;
    localparam logic [2:0] C_IDLE = 3'd0, C_ERPRE = 3'd1, C_ID = 3'd2, C_BUSY = 3'd3, C_QRY = 3'd4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_en = 1'b0;
    logic [15:0] rd_addr = '0;
    logic [1:0]  rd_width = 2'b00;
    logic [2:0]  cmd_state = 3'd0;
    logic        big_endian = 1'b0;
    logic [7:0]  stat_base = 8'h00;
    logic [15:0] arr_addr;
    logic [31:0] arr_bytes;
    logic [31:0] rd_data;
    logic        rd_valid;

    int total = 0;
    int bad = 0;
    bit fin = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [7:0] ab(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    always_comb arr_bytes = {ab(arr_addr + 16'd3), ab(arr_addr + 16'd2), ab(arr_addr + 16'd1), ab(arr_addr)};

    flash_rd_mux #(
        .SECT_BYTES (4096),
        .NUM_SECT   (16),
        .IDENT0     (ID0),
        .IDENT1     (ID1),
        .IDENT2     (ID2),
        .IDENT3     (ID3)
    ) u0 (
        .clk (clk), .rst (rst), .rd_en (rd_en), .rd_addr (rd_addr),
        .rd_width (rd_width), .cmd_state (cmd_state), .big_endian (big_endian),
        .stat_base (stat_base), .arr_addr (arr_addr), .arr_bytes (arr_bytes),
        .rd_data (rd_data), .rd_valid (rd_valid)
    );

    function automatic logic [31:0] exp_arr(input logic [15:0] a, input logic [1:0] w, input logic be);
        logic [7:0] b0, b1, b2, b3;
        b0 = ab(a); b1 = ab(a + 16'd1); b2 = ab(a + 16'd2); b3 = ab(a + 16'd3);
        if (w == 2'b00) return {24'h0, b0};
        if (w == 2'b01) return be ? {16'h0, b0, b1} : {16'h0, b1, b0};
        return be ? {b0, b1, b2, b3} : {b3, b2, b1, b0};
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic do_read(input logic [15:0] a, input logic [1:0] w, input logic [2:0] c,
                           output logic [31:0] d);
        @(negedge clk);
        rd_addr = a; rd_width = w; cmd_state = c; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
        check("R1 valid", {31'h0, rd_valid}, 32'h1);
    endtask

    task automatic t_reset;
        check("R10 data", rd_data, 32'h0);
        check("R10 valid", {31'h0, rd_valid}, 32'h0);
    endtask

    task automatic t_latency;
        logic [31:0] d, keep;
        do_read(16'h0040, 2'b10, C_IDLE, d);
        keep = d;
        @(negedge clk);
        check("R1 drop", {31'h0, rd_valid}, 32'h0);
        rd_addr = 16'h1234; cmd_state = C_QRY;
        @(negedge clk);
        check("R1 hold", rd_data, keep);
    endtask

    task automatic t_byte;
        logic [31:0] d;
        do_read(16'h0000, 2'b00, C_IDLE, d); check("R2 byte0", d, exp_arr(16'h0000, 2'b00, 1'b0));
        do_read(16'hA5C3, 2'b00, C_IDLE, d); check("R2 byteA", d, exp_arr(16'hA5C3, 2'b00, 1'b0));
        do_read(16'hFFFF, 2'b00, C_IDLE, d); check("R2 top",   d, exp_arr(16'hFFFF, 2'b00, 1'b0));
    endtask

    task automatic t_order;
        logic [31:0] d;
        big_endian = 1'b0;
        do_read(16'h0100, 2'b01, C_IDLE, d); check("R3 half le", d, exp_arr(16'h0100, 2'b01, 1'b0));
        do_read(16'h0204, 2'b10, C_IDLE, d); check("R3 word le", d, exp_arr(16'h0204, 2'b10, 1'b0));
        big_endian = 1'b1;
        do_read(16'h0100, 2'b01, C_IDLE, d); check("R3 half be", d, exp_arr(16'h0100, 2'b01, 1'b1));
        do_read(16'h0204, 2'b10, C_IDLE, d); check("R3 word be", d, exp_arr(16'h0204, 2'b10, 1'b1));
        do_read(16'h3008, 2'b11, C_IDLE, d); check("R3 w11 be",  d, exp_arr(16'h3008, 2'b11, 1'b1));
        big_endian = 1'b0;
    endtask

    task automatic t_ident;
        logic [31:0] d;
        do_read(16'h0000, 2'b00, C_ID, d); check("R5 id0", d, {16'h0, ID0});
        do_read(16'h0001, 2'b00, C_ID, d); check("R5 id1", d, {16'h0, ID1});
        do_read(16'h0002, 2'b00, C_ID, d); check("R5 prot", d, 32'h0);
        do_read(16'h0002, 2'b01, C_ID, d); check("R4 half off1", d, {16'h0, ID1});
        do_read(16'h0008, 2'b10, C_ID, d); check("R4 word off2", d, 32'h0);
        do_read(16'h0501, 2'b00, C_ID, d); check("R4 low bits", d, {16'h0, ID1});
        do_read(16'h000E, 2'b00, C_ID, d); check("R6 id2", d, {16'h0, ID2});
        do_read(16'h000F, 2'b00, C_ID, d); check("R6 id3 fallback", d, exp_arr(16'h000F, 2'b00, 1'b0));
        do_read(16'h0005, 2'b00, C_ID, d); check("R6 other", d, exp_arr(16'h0005, 2'b00, 1'b0));
    endtask

    task automatic t_status;
        logic [31:0] d;
        stat_base = 8'h80;
        do_read(16'h0000, 2'b00, C_BUSY, d); check("R7 first", d, 32'h80);
        do_read(16'h0000, 2'b00, C_BUSY, d); check("R7 second", d, 32'hC0);
        do_read(16'h0000, 2'b00, C_BUSY, d); check("R7 third", d, 32'h80);
        do_read(16'h0000, 2'b00, C_BUSY, d); check("R7 fourth", d, 32'hC0);
        do_read(16'h0000, 2'b00, C_BUSY, d); check("R7 fifth", d, 32'h80);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R10 data after reset", rd_data, 32'h0);
        do_read(16'h0000, 2'b00, C_BUSY, d); check("R10 toggle cleared", d, 32'h80);
    endtask

    task automatic t_query;
        logic [31:0] d;
        do_read(16'h0010, 2'b00, C_QRY, d); check("R8 Q", d, 32'h51);
        do_read(16'h0011, 2'b00, C_QRY, d); check("R8 R", d, 32'h52);
        do_read(16'h0048, 2'b10, C_QRY, d); check("R8 Y word", d, 32'h59);
        do_read(16'h0027, 2'b00, C_QRY, d); check("R8 size", d, 32'h10);
        do_read(16'h002D, 2'b00, C_QRY, d); check("R8 nsect lo", d, 32'h0F);
        do_read(16'h002E, 2'b00, C_QRY, d); check("R8 nsect hi", d, 32'h00);
        do_read(16'h005E, 2'b01, C_QRY, d); check("R8 sect mid", d, 32'h10);
        do_read(16'h0031, 2'b00, C_QRY, d); check("R8 P", d, 32'h50);
        do_read(16'h0052, 2'b00, C_QRY, d); check("R8 limit", d, 32'h0);
        do_read(16'h00FF, 2'b00, C_QRY, d); check("R8 beyond", d, 32'h0);
    endtask

    task automatic t_array_modes;
        logic [31:0] d;
        do_read(16'h0777, 2'b10, C_ERPRE, d); check("R9 erase prefix", d, exp_arr(16'h0777, 2'b10, 1'b0));
        do_read(16'h0002, 2'b00, 3'd6, d);    check("R9 unused code", d, exp_arr(16'h0002, 2'b00, 1'b0));
        do_read(16'h0010, 2'b00, 3'd7, d);    check("R9 code7", d, exp_arr(16'h0010, 2'b00, 1'b0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_latency();
        t_byte();
        t_order();
        t_ident();
        t_status();
        t_query();
        t_array_modes();
        fin = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!fin) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule